// File: doc/BRIEF.md
# Bus Idle Wait Timer

This block decides when a transmitter on a single-wire, open-drain control bus may drive the first start bit of a new frame. It measures how long the line has stayed high, in half-bit-period steps, and raises a grant once the required idle time has elapsed and a frame is waiting to go out. The grant stays high until the transmitter reports that it has begun the frame.

The required idle time comes from a 3-bit setting. A setting of zero picks the protocol default, which depends on the kind of frame waiting. A new initiator waits 7 bit periods. An initiator sending its next frame waits 5. A retransmission waits 3. A nonzero setting n picks n - 0.5 bit periods, so the range runs from 0.5 up to 6.5. A mode input selects the event that starts the count. It can be the frame request itself, or the end of any transmitted or received message. Any low level on the line restarts the count.

Top module: `sft_timer`

## Requirements
- R1: After reset `grant` is 0, and the count starts from zero with counting enabled.
- R2: With `sft_sel` = n (1..7), `grant` rises on the clock edge that samples the (2n-1)-th idle `half_tick` after the count starts. It stays 0 after 2n-2 such ticks.
- R3: With `sft_sel` = 0 and neither `frame_retry` nor `frame_next` set at the request, the wait is 14 half ticks.
- R4: With `sft_sel` = 0 and `frame_next` = 1 at the request, the wait is 10 half ticks.
- R5: With `sft_sel` = 0 and `frame_retry` = 1 at the request, the wait is 6 half ticks. `frame_retry` takes priority over `frame_next`.
- R6: With `start_on_end` = 0, an accepted `som_req` clears the count and starts it. Ticks seen before the request do not count, and `tx_eom`/`rx_eom` pulses have no effect.
- R7: With `start_on_end` = 1, a `tx_eom` or `rx_eom` pulse clears the count and starts it, and `som_req` does not restart it. If the wait has already elapsed, `grant` rises on the edge that samples `som_req`.
- R8: A clock edge that samples `line_idle` = 0 clears the count to zero, even if `half_tick` is also high.
- R9: Once high, `grant` holds until an edge samples `tx_started` = 1. On that edge `grant` clears and counting stops until the next start event.
- R10: A `som_req` while a frame is already pending is ignored. It does not restart the count and does not change the frame class.
- R11: The count saturates at its maximum instead of wrapping. A long idle period before the request still grants with the largest setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| line_idle | input | 1 | 1 while the sampled bus line is high |
| sft_sel | input | 3 | Idle-time setting: 0 = protocol default, n = n-0.5 bit periods |
| start_on_end | input | 1 | 0: count starts at the request; 1: count starts at end of message |
| som_req | input | 1 | Pulse: software requests a frame start |
| frame_retry | input | 1 | Pending frame is a retransmission (sampled with som_req) |
| frame_next | input | 1 | Pending frame is the initiator's next frame (sampled with som_req) |
| tx_eom | input | 1 | Pulse: end of a transmitted message |
| rx_eom | input | 1 | Pulse: end of a received message |
| tx_started | input | 1 | Transmitter acknowledges that it has begun the frame |
| grant | output | 1 | Transmitter may drive the first start bit |

## Verification
The bench aims at off-by-one errors in the half-tick target. It checks the grant one tick before and exactly at each target, so a design that counts whole bits or uses 2n instead of 2n-1 grants a tick late or early. It drives a low line in the middle of a count, sends a second request and a stray end-of-message pulse in request mode, and sends a request after the wait has already elapsed in end-of-message mode. A design that restarts on the wrong event, or fails to restart on the right one, grants at the wrong time. A long idle period with the largest setting catches a counter that wraps instead of saturating, because such a design withholds the grant.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [1:0] {
        CLS_NEW   = 2'd0,
        CLS_NEXT  = 2'd1,
        CLS_RETRY = 2'd2
    } frame_cls_e;

    typedef struct packed {
        logic       running;
        logic       pending;
        frame_cls_e cls;
        logic       grant;
    } ctl_t;

    // Largest wait in half-bit ticks over all settings and frame classes.
    function automatic int half_max(int sel_w, int d_new, int d_next, int d_retry);
        int m;
        m = 2 * (2 ** sel_w - 1) - 1;
        if (2 * d_new   > m) m = 2 * d_new;
        if (2 * d_next  > m) m = 2 * d_next;
        if (2 * d_retry > m) m = 2 * d_retry;
        return m;
    endfunction

endpackage

// File: rtl/sft_target.sv
module sft_target
    import sft_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int CNT_W     = 4,
    parameter int DEF_NEW   = 7,
    parameter int DEF_NEXT  = 5,
    parameter int DEF_RETRY = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  frame_cls_e       cls,
    output logic [CNT_W-1:0] tgt
);
    // Wait length in half-bit ticks.
    always_comb begin
        if (sel == '0) begin
            unique case (cls)
                CLS_RETRY: tgt = CNT_W'(2 * DEF_RETRY);
                CLS_NEXT:  tgt = CNT_W'(2 * DEF_NEXT);
                default:   tgt = CNT_W'(2 * DEF_NEW);
            endcase
        end else begin
            tgt = CNT_W'(2 * int'(sel) - 1);
        end
    end
endmodule

// File: rtl/sft_halfcount.sv
module sft_halfcount #(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic             idle,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !idle) begin
            cnt_d = '0;
        end else if (run && tick && (cnt_q != CNT_W'(CNT_MAX))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_nxt = cnt_d;
    assign cnt     = cnt_q;

    // R8
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> (cnt_q == '0));

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && idle && !clr && cnt_q == CNT_W'(CNT_MAX)) |=> (cnt_q == CNT_W'(CNT_MAX)));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && idle && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/sft_timer.sv
module sft_timer
    import sft_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int DEF_NEW   = 7,
    parameter int DEF_NEXT  = 5,
    parameter int DEF_RETRY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             line_idle,
    input  logic [SEL_W-1:0] sft_sel,
    input  logic             start_on_end,
    input  logic             som_req,
    input  logic             frame_retry,
    input  logic             frame_next,
    input  logic             tx_eom,
    input  logic             rx_eom,
    input  logic             tx_started,
    output logic             grant
);
    localparam int HALF_MAX = sft_pkg::half_max(SEL_W, DEF_NEW, DEF_NEXT, DEF_RETRY);
    localparam int CNT_W    = $clog2(HALF_MAX + 1);
    localparam int CNT_MAX  = (1 << CNT_W) - 1;

    ctl_t             ctl_d, ctl_q;
    logic             acc_req, restart, ack;
    frame_cls_e       req_cls;
    logic [CNT_W-1:0] cnt_nxt, cnt_q;
    logic [CNT_W-1:0] tgt_nxt, tgt_q;

    assign req_cls = frame_retry ? CLS_RETRY : (frame_next ? CLS_NEXT : CLS_NEW);
    assign acc_req = som_req && !ctl_q.pending;
    assign ack     = ctl_q.grant && tx_started;
    assign restart = start_on_end ? (tx_eom || rx_eom) : acc_req;

    sft_halfcount #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart || ack),
        .run     (ctl_q.running),
        .tick    (half_tick),
        .idle    (line_idle),
        .cnt_nxt (cnt_nxt),
        .cnt     (cnt_q)
    );

    sft_target #(.SEL_W(SEL_W), .CNT_W(CNT_W), .DEF_NEW(DEF_NEW),
                 .DEF_NEXT(DEF_NEXT), .DEF_RETRY(DEF_RETRY)) u_tgt_nxt (
        .sel (sft_sel),
        .cls (ctl_d.cls),
        .tgt (tgt_nxt)
    );

    sft_target #(.SEL_W(SEL_W), .CNT_W(CNT_W), .DEF_NEW(DEF_NEW),
                 .DEF_NEXT(DEF_NEXT), .DEF_RETRY(DEF_RETRY)) u_tgt_cur (
        .sel (sft_sel),
        .cls (ctl_q.cls),
        .tgt (tgt_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (acc_req) begin
            ctl_d.pending = 1'b1;
            ctl_d.cls     = req_cls;
        end
        if (restart) ctl_d.running = 1'b1;
        if (ack) begin
            ctl_d.pending = 1'b0;
            ctl_d.running = 1'b0;
        end
        if (ctl_q.grant) begin
            ctl_d.grant = !ack;
        end else begin
            ctl_d.grant = ctl_d.pending && ctl_d.running && (cnt_nxt >= tgt_nxt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.running <= 1'b1;
            ctl_q.pending <= 1'b0;
            ctl_q.cls     <= CLS_NEW;
            ctl_q.grant   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign grant = ctl_q.grant;

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !tx_started) |=> grant);

    // R9
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && tx_started) |=> !grant);

    // R2
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant) && $stable(sft_sel)) |-> (cnt_q >= tgt_q));

    // R10
    grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ctl_q.pending);

    // R10
    class_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pending && !ack) |=> $stable(ctl_q.cls));
endmodule

// File: tb/sft_timer_bench.sv
module sft_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       line_idle = 1'b1;
    logic [2:0] sft_sel = 3'd0;
    logic       start_on_end = 1'b0;
    logic       som_req = 1'b0;
    logic       frame_retry = 1'b0;
    logic       frame_next = 1'b0;
    logic       tx_eom = 1'b0;
    logic       rx_eom = 1'b0;
    logic       tx_started = 1'b0;
    logic       grant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sft_timer u_sft_timer (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .line_idle(line_idle),
        .sft_sel(sft_sel), .start_on_end(start_on_end), .som_req(som_req),
        .frame_retry(frame_retry), .frame_next(frame_next), .tx_eom(tx_eom),
        .rx_eom(rx_eom), .tx_started(tx_started), .grant(grant)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s grant actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            half_tick = 1'b1;
            step();
            half_tick = 1'b0;
        end
    endtask

    task automatic request(input logic retry, input logic nxt);
        frame_retry = retry;
        frame_next  = nxt;
        som_req     = 1'b1;
        step();
        som_req     = 1'b0;
        frame_retry = 1'b0;
        frame_next  = 1'b0;
    endtask

    task automatic acknowledge(input string req);
        tx_started = 1'b1;
        step();
        tx_started = 1'b0;
        chk(req, grant, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        chk("R1", grant, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1", grant, 1'b0);
    endtask

    task automatic t_setting(input int n);
        start_on_end = 1'b0;
        sft_sel = 3'(n);
        ticks(20);                 // R6: ticks before the request do not count
        request(1'b0, 1'b0);
        chk("R6", grant, 1'b0);
        ticks(2 * n - 2);
        chk("R2", grant, 1'b0);
        ticks(1);
        chk("R2", grant, 1'b1);
        step();
        step();
        chk("R9", grant, 1'b1);
        acknowledge("R9");
    endtask

    task automatic t_default(input logic retry, input logic nxt, input int halves, input string req);
        start_on_end = 1'b0;
        sft_sel = 3'd0;
        request(retry, nxt);
        ticks(halves - 1);
        chk(req, grant, 1'b0);
        ticks(1);
        chk(req, grant, 1'b1);
        acknowledge("R9");
    endtask

    task automatic t_line_low();
        start_on_end = 1'b0;
        sft_sel = 3'd3;
        request(1'b0, 1'b0);
        ticks(3);
        line_idle = 1'b0;
        ticks(1);
        line_idle = 1'b1;
        ticks(4);
        chk("R8", grant, 1'b0);
        ticks(1);
        chk("R8", grant, 1'b1);
        acknowledge("R9");
    endtask

    task automatic t_ignored();
        start_on_end = 1'b0;
        sft_sel = 3'd2;
        request(1'b0, 1'b0);
        ticks(2);
        request(1'b0, 1'b0);       // R10: second request ignored
        ticks(1);
        chk("R10", grant, 1'b1);
        acknowledge("R9");
        request(1'b0, 1'b0);
        ticks(2);
        tx_eom = 1'b1;             // R6: end-of-message has no effect in request mode
        rx_eom = 1'b1;
        step();
        tx_eom = 1'b0;
        rx_eom = 1'b0;
        ticks(1);
        chk("R6", grant, 1'b1);
        acknowledge("R9");
    endtask

    task automatic t_auto();
        start_on_end = 1'b1;
        sft_sel = 3'd2;
        tx_eom = 1'b1;
        step();
        tx_eom = 1'b0;
        ticks(2);
        request(1'b0, 1'b0);       // R7: request does not restart the count
        chk("R7", grant, 1'b0);
        ticks(1);
        chk("R7", grant, 1'b1);
        acknowledge("R9");
        ticks(10);                 // R9: counting stopped after ack
        request(1'b0, 1'b0);
        chk("R9", grant, 1'b0);
        rx_eom = 1'b1;
        step();
        rx_eom = 1'b0;
        ticks(2);
        chk("R7", grant, 1'b0);
        ticks(1);
        chk("R7", grant, 1'b1);
        acknowledge("R9");
        sft_sel = 3'd7;
        rx_eom = 1'b1;
        step();
        rx_eom = 1'b0;
        ticks(18);                 // R11: long idle must saturate, not wrap
        request(1'b0, 1'b0);
        chk("R11", grant, 1'b1);
        acknowledge("R9");
        start_on_end = 1'b0;
    endtask

    initial begin
        t_reset();
        t_setting(1);
        t_setting(4);
        t_setting(7);
        t_default(1'b0, 1'b0, 14, "R3");
        t_default(1'b0, 1'b1, 10, "R4");
        t_default(1'b1, 1'b0, 6, "R5");
        t_default(1'b1, 1'b1, 6, "R5");
        t_line_low();
        t_ignored();
        t_auto();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule